// File: doc/BRIEF.md
# Instruction Decode Stage with Pending-Register Scoreboard

This block is the decode step of a small pipeline that runs both scalar and vector operations. Each cycle it takes one 32-bit instruction word on a valid/ready stream. It works out the format and operation, pulls out the register fields and the immediate, and sends a decoded bundle downstream on a second valid/ready stream. The bundle comes out in the same cycle the instruction is presented.

Before an instruction may pass, every register it reads is looked up in a scoreboard. The scoreboard holds one pending bit per scalar register and one per vector register. A hit holds the instruction at the input. When an instruction is handed over, the registers it will write are marked pending. Writeback later retires them through two clear ports, one for scalar registers and one for vector registers.

Back-pressure rules:
- `in_ready` is high only when `out_ready` is high and no source register is pending.
- `out_valid` is high when `in_valid` is high and no source register is pending. It does not depend on `out_ready`.
- A transfer happens when `in_valid` and `in_ready` are both high. Scoreboard claims are made only on a transfer.

Top module: `decode_stage`

## Requirements
- R1: Bits [1:0] of the instruction select the format. The codes are 00 = R, 01 = I, 10 = J and 11 = undefined. An undefined format decodes as no-op: `out_op` 0, nothing read, nothing claimed, never stalls.
- R2: The operation is looked up with the opcode placed above the format bits.
  - R opcodes sit in bits [6:2]: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 compare, 6 vadd, 7 vsub, 8 vmul, 9 vcompare.
  - I opcodes sit in bits [5:2]: 0 addi, 1 andi, 2 load, 3 store, 4 vload, 5 vstore.
  - J opcodes sit in bits [5:2]: 0 jump, 1 push, 2 pop, 3 return.
  - Any other code is a no-op.
  - `out_op` codes: 0 nop, 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 cmp, 7 vadd, 8 vsub, 9 vmul, 10 vcmp, 11 addi, 12 andi, 13 load, 14 store, 15 vload, 16 vstore, 17 jump, 18 push, 19 pop, 20 ret.
- R3: R fields are: first source at bits [11:7], second source at [16:12], destination at [21:17]. If any register an instruction reads is pending, `in_ready` and `out_valid` are both low.
- R4: Destinations are claimed only on a transfer. Register 0 is never claimed, in either file, and a destination of 0 gives `out_dst_en` = 0.
- R5: Scalar compare and vector compare claim no destination.
- R6: In I format, field A is bits [10:6] and field B is bits [15:11].
  - A load writes field A and reads its base from field B.
  - A store reads its base from field A and its data from field B.
  - `out_src_a` is the base register.
- R7: Immediates are sign-extended to 32 bits. The I immediate is bits [31:16]. The J immediate is bits [31:11].
- R8: Push and pop use scalar register 2 as the stack pointer, and both write it (`out_sp_wr` = 1).
  - Push reads field A and register 2, and gives a step of -1 on `out_imm`.
  - Pop reads register 2, claims field A, and gives a step of +1.
- R9: Return reads scalar register 1 and ignores field A. A jump reads field A (bits [10:6]).
- R10: Vector arithmetic, vector compare, vector load and vector store also read scalar register 4. `out_vlen` is the low 4 bits of `vlen_src`, limited to MAX_LANES (default 8). Vector registers are tracked apart from scalar registers with the same number.
- R11: A clear port drops the pending bit it names on the next clock edge. If a claim names the same register in the same cycle, the claim wins.
- R12: While `out_ready` is low, nothing transfers and nothing is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the scoreboard |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_insn | input | 32 | Instruction word |
| vlen_src | input | 32 | Value of scalar register 4, from the register file |
| out_valid | output | 1 | Decoded bundle present |
| out_ready | input | 1 | Downstream can take the bundle |
| out_op | output | 5 | Operation code (see R2) |
| out_src_a | output | 5 | First source register index (base register for memory operations) |
| out_src_b | output | 5 | Second source register index |
| out_dst | output | 5 | Claimed destination index, 0 when none |
| out_dst_en | output | 1 | A destination is claimed |
| out_dst_vec | output | 1 | The destination is a vector register |
| out_sp_wr | output | 1 | The stack pointer (register 2) is claimed |
| out_imm | output | 32 | Sign-extended immediate or stack step |
| out_vlen | output | 4 | Clamped vector length, 0 for non-vector operations |
| clr_s_en | input | 1 | Clear one scalar pending bit |
| clr_s_idx | input | 5 | Scalar register to clear |
| clr_v_en | input | 1 | Clear one vector pending bit |
| clr_v_idx | input | 5 | Vector register to clear |

## Verification
The scoreboard is the only state, so any wrong internal state shows up at the ports as a stall or a missing stall. That happens the first time a later instruction reads the register in question, at the earliest one cycle after the faulty claim or clear.

The bench follows each claim with a reader of the same register, and checks whether the reader is held or passes. It also reads the same number in the other register file, and repeats the checks after each clear, including a clear and a claim in the same cycle.

Decode faults are visible in the same cycle on the bundle fields.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int INSN_W   = 32;
  localparam int FMT_W    = 2;
  localparam int RIDX_W   = 5;
  localparam int ROPC_W   = 5;
  localparam int XOPC_W   = 4;
  localparam int KEY_W    = ROPC_W + FMT_W;
  localparam int VMASK_W  = 4;
  localparam int OPOUT_W  = 5;
  // field positions derived from the widths above
  localparam int R_F0     = FMT_W + ROPC_W;
  localparam int X_F0     = FMT_W + XOPC_W;
  localparam int I_IMM_LO = X_F0 + 2 * RIDX_W;
  localparam int J_IMM_LO = X_F0 + RIDX_W;

  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(1);
  localparam logic [RIDX_W-1:0] SP_REG   = RIDX_W'(2);
  localparam logic [RIDX_W-1:0] VLEN_REG = RIDX_W'(4);

  typedef enum logic [FMT_W-1:0] {
    FMT_R = 2'b00, FMT_I = 2'b01, FMT_J = 2'b10, FMT_X = 2'b11
  } fmt_e;

  typedef enum logic [OPOUT_W-1:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP,
    OP_VADD, OP_VSUB, OP_VMUL, OP_VCMP,
    OP_ADDI, OP_ANDI, OP_LOAD, OP_STORE, OP_VLOAD, OP_VSTORE,
    OP_JUMP, OP_PUSH, OP_POP, OP_RET
  } op_e;

  typedef struct packed {
    logic              en;
    logic              vec;
    logic [RIDX_W-1:0] idx;
  } reg_use_t;
endpackage

// File: rtl/dec_classify.sv
module dec_classify
  import dec_pkg::*;
#(
  parameter int N_SRC = 3,
  parameter int N_DST = 2
) (
  input  logic [INSN_W-1:0] insn,
  output op_e               op,
  output reg_use_t          src [N_SRC],
  output reg_use_t          dst [N_DST],
  output logic [INSN_W-1:0] imm,
  output logic              uses_vlen
);
  logic [FMT_W-1:0]  fmt;
  logic [KEY_W-1:0]  key;
  logic [RIDX_W-1:0] r_a, r_b, r_d, x_a, x_b;
  logic [INSN_W-1:0] imm_i, imm_j;

  assign fmt   = insn[FMT_W-1:0];
  assign r_a   = insn[R_F0 +: RIDX_W];
  assign r_b   = insn[R_F0 + RIDX_W +: RIDX_W];
  assign r_d   = insn[R_F0 + 2*RIDX_W +: RIDX_W];
  assign x_a   = insn[X_F0 +: RIDX_W];
  assign x_b   = insn[X_F0 + RIDX_W +: RIDX_W];
  assign imm_i = INSN_W'($signed(insn[INSN_W-1:I_IMM_LO]));
  assign imm_j = INSN_W'($signed(insn[INSN_W-1:J_IMM_LO]));

  // lookup key: opcode stacked above the format bits
  always_comb begin
    if (fmt == FMT_R) key = {insn[FMT_W +: ROPC_W], fmt};
    else              key = KEY_W'({insn[FMT_W +: XOPC_W], fmt});
  end

  always_comb begin
    op = OP_NOP;
    if (fmt != FMT_X) begin
      case (key)
        {5'd0, FMT_R}: op = OP_ADD;
        {5'd1, FMT_R}: op = OP_SUB;
        {5'd2, FMT_R}: op = OP_AND;
        {5'd3, FMT_R}: op = OP_OR;
        {5'd4, FMT_R}: op = OP_XOR;
        {5'd5, FMT_R}: op = OP_CMP;
        {5'd6, FMT_R}: op = OP_VADD;
        {5'd7, FMT_R}: op = OP_VSUB;
        {5'd8, FMT_R}: op = OP_VMUL;
        {5'd9, FMT_R}: op = OP_VCMP;
        {1'b0, 4'd0, FMT_I}: op = OP_ADDI;
        {1'b0, 4'd1, FMT_I}: op = OP_ANDI;
        {1'b0, 4'd2, FMT_I}: op = OP_LOAD;
        {1'b0, 4'd3, FMT_I}: op = OP_STORE;
        {1'b0, 4'd4, FMT_I}: op = OP_VLOAD;
        {1'b0, 4'd5, FMT_I}: op = OP_VSTORE;
        {1'b0, 4'd0, FMT_J}: op = OP_JUMP;
        {1'b0, 4'd1, FMT_J}: op = OP_PUSH;
        {1'b0, 4'd2, FMT_J}: op = OP_POP;
        {1'b0, 4'd3, FMT_J}: op = OP_RET;
        default:             op = OP_NOP;
      endcase
    end
  end

  // operand roles per operation; slot 2 carries the implicit register
  always_comb begin
    for (int i = 0; i < N_SRC; i++) src[i] = '0;
    for (int i = 0; i < N_DST; i++) dst[i] = '0;
    imm       = '0;
    uses_vlen = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
        src[0] = '{1'b1, 1'b0, r_a};
        src[1] = '{1'b1, 1'b0, r_b};
        dst[0] = '{r_d != '0, 1'b0, r_d};
      end
      OP_CMP: begin
        src[0] = '{1'b1, 1'b0, r_a};
        src[1] = '{1'b1, 1'b0, r_b};
      end
      OP_VADD, OP_VSUB, OP_VMUL, OP_VCMP: begin
        src[0]    = '{1'b1, 1'b1, r_a};
        src[1]    = '{1'b1, 1'b1, r_b};
        src[2]    = '{1'b1, 1'b0, VLEN_REG};
        uses_vlen = 1'b1;
        if (op != OP_VCMP) dst[0] = '{r_d != '0, 1'b1, r_d};
      end
      OP_ADDI, OP_ANDI: begin
        src[0] = '{1'b1, 1'b0, x_a};
        dst[0] = '{x_b != '0, 1'b0, x_b};
        imm    = imm_i;
      end
      OP_LOAD: begin
        src[0] = '{1'b1, 1'b0, x_b};
        dst[0] = '{x_a != '0, 1'b0, x_a};
        imm    = imm_i;
      end
      OP_STORE: begin
        src[0] = '{1'b1, 1'b0, x_a};
        src[1] = '{1'b1, 1'b0, x_b};
        imm    = imm_i;
      end
      OP_VLOAD: begin
        src[0]    = '{1'b1, 1'b0, x_b};
        src[2]    = '{1'b1, 1'b0, VLEN_REG};
        dst[0]    = '{x_a != '0, 1'b1, x_a};
        imm       = imm_i;
        uses_vlen = 1'b1;
      end
      OP_VSTORE: begin
        src[0]    = '{1'b1, 1'b0, x_a};
        src[1]    = '{1'b1, 1'b1, x_b};
        src[2]    = '{1'b1, 1'b0, VLEN_REG};
        imm       = imm_i;
        uses_vlen = 1'b1;
      end
      OP_JUMP: begin
        src[0] = '{1'b1, 1'b0, x_a};
        imm    = imm_j;
      end
      OP_PUSH: begin
        src[0] = '{1'b1, 1'b0, x_a};
        src[2] = '{1'b1, 1'b0, SP_REG};
        dst[1] = '{1'b1, 1'b0, SP_REG};
        imm    = '1;
      end
      OP_POP: begin
        src[2] = '{1'b1, 1'b0, SP_REG};
        dst[0] = '{x_a != '0, 1'b0, x_a};
        dst[1] = '{1'b1, 1'b0, SP_REG};
        imm    = INSN_W'(1);
      end
      OP_RET: begin
        src[0] = '{1'b1, 1'b0, LINK_REG};
        imm    = imm_j;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_scoreboard.sv
module dec_scoreboard
  import dec_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int N_SRC    = 3,
  parameter int N_DST    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_use_t          src [N_SRC],
  input  reg_use_t          dst [N_DST],
  input  logic              claim,
  input  logic              clr_s_en,
  input  logic [RIDX_W-1:0] clr_s_idx,
  input  logic              clr_v_en,
  input  logic [RIDX_W-1:0] clr_v_idx,
  output logic              busy
);
  logic [NUM_REGS-1:0] spend_q, vpend_q, s_set, v_set, s_clr, v_clr;
  logic [N_SRC-1:0]    hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src[g].en &
                    (src[g].vec ? vpend_q[src[g].idx] : spend_q[src[g].idx]);
  end
  assign busy = |hit;

  always_comb begin
    s_set = '0;
    v_set = '0;
    s_clr = '0;
    v_clr = '0;
    if (clr_s_en) s_clr[clr_s_idx] = 1'b1;
    if (clr_v_en) v_clr[clr_v_idx] = 1'b1;
    if (claim) begin
      for (int d = 0; d < N_DST; d++) begin
        if (dst[d].en && !dst[d].vec) s_set[dst[d].idx] = 1'b1;
        if (dst[d].en &&  dst[d].vec) v_set[dst[d].idx] = 1'b1;
      end
    end
    s_set[0] = 1'b0;
    v_set[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spend_q <= '0;
      vpend_q <= '0;
    end else begin
      spend_q <= (spend_q & ~s_clr) | s_set;
      vpend_q <= (vpend_q & ~v_clr) | v_set;
    end
  end
endmodule

// File: rtl/decode_stage.sv
module decode_stage
  import dec_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int MAX_LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [INSN_W-1:0]   in_insn,
  input  logic [INSN_W-1:0]   vlen_src,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OPOUT_W-1:0]  out_op,
  output logic [RIDX_W-1:0]   out_src_a,
  output logic [RIDX_W-1:0]   out_src_b,
  output logic [RIDX_W-1:0]   out_dst,
  output logic                out_dst_en,
  output logic                out_dst_vec,
  output logic                out_sp_wr,
  output logic [INSN_W-1:0]   out_imm,
  output logic [VMASK_W-1:0]  out_vlen,
  input  logic                clr_s_en,
  input  logic [RIDX_W-1:0]   clr_s_idx,
  input  logic                clr_v_en,
  input  logic [RIDX_W-1:0]   clr_v_idx
);
  localparam int N_SRC = 3;
  localparam int N_DST = 2;
  localparam logic [VMASK_W-1:0] LANE_CAP = VMASK_W'(MAX_LANES);

  op_e               op;
  reg_use_t          src [N_SRC];
  reg_use_t          dst [N_DST];
  logic [INSN_W-1:0] imm;
  logic              uses_vlen, busy;
  logic [VMASK_W-1:0] vlen_raw;

  dec_classify #(.N_SRC(N_SRC), .N_DST(N_DST)) cls_i (
    .insn(in_insn), .op(op), .src(src), .dst(dst), .imm(imm),
    .uses_vlen(uses_vlen)
  );

  dec_scoreboard #(.NUM_REGS(NUM_REGS), .N_SRC(N_SRC), .N_DST(N_DST)) sb_i (
    .clk(clk), .rst_n(rst_n), .src(src), .dst(dst),
    .claim(in_valid && in_ready),
    .clr_s_en(clr_s_en), .clr_s_idx(clr_s_idx),
    .clr_v_en(clr_v_en), .clr_v_idx(clr_v_idx),
    .busy(busy)
  );

  assign in_ready  = out_ready && !busy;
  assign out_valid = in_valid && !busy;

  assign vlen_raw    = vlen_src[VMASK_W-1:0];
  assign out_vlen    = !uses_vlen ? '0 : (vlen_raw > LANE_CAP ? LANE_CAP : vlen_raw);
  assign out_op      = OPOUT_W'(op);
  assign out_src_a   = src[0].idx;
  assign out_src_b   = src[1].idx;
  assign out_dst_en  = dst[0].en;
  assign out_dst     = dst[0].en ? dst[0].idx : '0;
  assign out_dst_vec = dst[0].en && dst[0].vec;
  assign out_sp_wr   = dst[1].en;
  assign out_imm     = imm;
endmodule

// File: rtl/decode_stage_chk.sv
module decode_stage_chk
  import dec_pkg::*;
#(
  parameter int MAX_LANES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OPOUT_W-1:0] out_op,
  input logic [RIDX_W-1:0]  out_dst,
  input logic               out_dst_en,
  input logic               out_sp_wr,
  input logic [INSN_W-1:0]  out_imm,
  input logic [VMASK_W-1:0] out_vlen
);
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid); // R3
  AST_STALL_BLOCKS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !in_ready) |-> !out_valid); // R3
  AST_READY_FOLLOWS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready); // R12
  AST_ZERO_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dst_en) |-> (out_dst != '0)); // R4
  AST_COMPARE_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == OP_CMP || out_op == OP_VCMP)) |-> !out_dst_en); // R5
  AST_VLEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_vlen) <= MAX_LANES)); // R10
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_PUSH) |-> (out_sp_wr && out_imm == '1)); // R8
  AST_NOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_NOP) |-> (!out_dst_en && !out_sp_wr)); // R2
endmodule

bind decode_stage decode_stage_chk #(.MAX_LANES(MAX_LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_dst(out_dst), .out_dst_en(out_dst_en), .out_sp_wr(out_sp_wr),
  .out_imm(out_imm), .out_vlen(out_vlen)
);

// File: tb/decode_stage_tb_top.sv
`timescale 1ns/1ps
module decode_stage_tb_top;
  import dec_pkg::*;

  typedef struct packed {
    logic [4:0]  op;
    logic [4:0]  src_a;
    logic [4:0]  dst;
    logic        dst_en;
    logic        dst_vec;
    logic        sp_wr;
    logic [31:0] imm;
    logic [3:0]  vlen;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [31:0] in_insn = '0, vlen_src = '0;
  logic clr_s_en = 0, clr_v_en = 0;
  logic [4:0] clr_s_idx = '0, clr_v_idx = '0;
  logic in_ready, out_valid, out_dst_en, out_dst_vec, out_sp_wr;
  logic [4:0] out_op, out_src_a, out_src_b, out_dst;
  logic [31:0] out_imm;
  logic [3:0] out_vlen;

  int n_chk = 0, n_bad = 0;
  exp_t exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  decode_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .vlen_src(vlen_src), .out_valid(out_valid),
    .out_ready(out_ready), .out_op(out_op), .out_src_a(out_src_a),
    .out_src_b(out_src_b), .out_dst(out_dst), .out_dst_en(out_dst_en),
    .out_dst_vec(out_dst_vec), .out_sp_wr(out_sp_wr), .out_imm(out_imm),
    .out_vlen(out_vlen), .clr_s_en(clr_s_en), .clr_s_idx(clr_s_idx),
    .clr_v_en(clr_v_en), .clr_v_idx(clr_v_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] r_w(int opc, int a, int b, int d);
    return {10'b0, 5'(d), 5'(b), 5'(a), 5'(opc), 2'b00};
  endfunction
  function automatic logic [31:0] i_w(int opc, int fa, int fb, logic [15:0] im);
    return {im, 5'(fb), 5'(fa), 4'(opc), 2'b01};
  endfunction
  function automatic logic [31:0] j_w(int opc, int fa, logic [20:0] im);
    return {im, 5'(fa), 4'(opc), 2'b10};
  endfunction
  function automatic exp_t mk(op_e op, int sa, int d, bit den, bit dv, bit sp,
                              logic [31:0] im, int vl);
    exp_t e;
    e.op = 5'(op); e.src_a = 5'(sa); e.dst = 5'(d); e.dst_en = den;
    e.dst_vec = dv; e.sp_wr = sp; e.imm = im; e.vlen = 4'(vl);
    return e;
  endfunction

  // driver: one instruction, expected result queued unless a stall is expected
  task automatic send(input logic [31:0] w, input bit stall, input exp_t e,
                      input int clr_s, input string req);
    @(posedge clk); #1;
    in_valid = 1; in_insn = w;
    if (clr_s >= 0) begin clr_s_en = 1; clr_s_idx = 5'(clr_s); end
    if (!stall) begin exp_q.push_back(e); req_q.push_back(req); end
    @(negedge clk);
    if (stall) chk(!in_ready && !out_valid, req, "stall expected",
                   64'({in_ready, out_valid}), 64'(0));
    @(posedge clk); #1;
    in_valid = 0; clr_s_en = 0;
  endtask

  task automatic clr(input bit vec, input int idx);
    @(posedge clk); #1;
    if (vec) begin clr_v_en = 1; clr_v_idx = 5'(idx); end
    else     begin clr_s_en = 1; clr_s_idx = 5'(idx); end
    @(posedge clk); #1;
    clr_v_en = 0; clr_s_en = 0;
  endtask

  // monitor: compares every transferred bundle against the queue
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t a;
      a = '{out_op, out_src_a, out_dst, out_dst_en, out_dst_vec, out_sp_wr, out_imm, out_vlen};
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected transfer", 64'(a), 64'(0));
      else begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(a == e, r, "bundle", 64'(a), 64'(e));
      end
    end
  end

  localparam exp_t NONE = '0;

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!out_valid, "R3", "reset idle", 64'(out_valid), 64'(0));
        // R3: claim then hazard
        send(r_w(0, 1, 2, 3), 0, mk(OP_ADD, 1, 3, 1, 0, 0, 0, 0), -1, "R3");
        send(r_w(0, 3, 4, 5), 1, NONE, -1, "R3");
        clr(0, 3);                                                   // R11
        send(r_w(0, 3, 4, 5), 0, mk(OP_ADD, 3, 5, 1, 0, 0, 0, 0), -1, "R11");
        // R4: register 0 destination
        send(r_w(0, 1, 2, 0), 0, mk(OP_ADD, 1, 0, 0, 0, 0, 0, 0), -1, "R4");
        // R5: compare claims nothing; reader of its rd field passes
        send(r_w(5, 6, 7, 9), 0, mk(OP_CMP, 6, 0, 0, 0, 0, 0, 0), -1, "R5");
        send(r_w(0, 9, 0, 10), 0, mk(OP_ADD, 9, 10, 1, 0, 0, 0, 0), -1, "R5");
        // R6 R7: load roles and immediate
        send(i_w(2, 8, 9, 16'hFFFC), 0, mk(OP_LOAD, 9, 8, 1, 0, 0, 32'hFFFFFFFC, 0), -1, "R6");
        send(i_w(3, 8, 11, 16'h0005), 1, NONE, -1, "R6");
        send(i_w(3, 11, 8, 16'h0005), 1, NONE, -1, "R6");
        clr(0, 8);
        send(i_w(3, 11, 8, 16'h0005), 0, mk(OP_STORE, 11, 0, 0, 0, 0, 32'h5, 0), -1, "R6");
        // R9 R7: jump
        send(j_w(0, 12, 21'h1FFFF0), 0, mk(OP_JUMP, 12, 0, 0, 0, 0, 32'hFFFFFFF0, 0), -1, "R7");
        send(j_w(0, 10, 21'h0), 1, NONE, -1, "R9");
        // R8: push / pop
        send(j_w(1, 13, 21'h0), 0, mk(OP_PUSH, 13, 0, 0, 0, 1, 32'hFFFFFFFF, 0), -1, "R8");
        send(j_w(2, 14, 21'h0), 1, NONE, -1, "R8");
        clr(0, 2);
        send(j_w(2, 14, 21'h0), 0, mk(OP_POP, 0, 14, 1, 0, 1, 32'h1, 0), -1, "R8");
        send(j_w(1, 13, 21'h0), 1, NONE, -1, "R8");
        clr(0, 2);
        // R9: return uses register 1, not field A
        send(r_w(0, 0, 0, 1), 0, mk(OP_ADD, 0, 1, 1, 0, 0, 0, 0), -1, "R9");
        send(j_w(3, 7, 21'h0), 1, NONE, -1, "R9");
        clr(0, 1);
        send(j_w(3, 7, 21'h0), 0, mk(OP_RET, 1, 0, 0, 0, 0, 0, 0), -1, "R9");
        // R10: vector length clamp and separate vector tracking
        vlen_src = 32'h2B;
        send(r_w(6, 1, 2, 3), 0, mk(OP_VADD, 1, 3, 1, 1, 0, 0, 8), -1, "R10");
        vlen_src = 32'h15;
        send(r_w(7, 3, 1, 6), 1, NONE, -1, "R10");
        send(r_w(0, 3, 0, 7), 0, mk(OP_ADD, 3, 7, 1, 0, 0, 0, 0), -1, "R10");
        send(r_w(8, 1, 2, 6), 0, mk(OP_VMUL, 1, 6, 1, 1, 0, 0, 5), -1, "R10");
        send(r_w(0, 0, 0, 4), 0, mk(OP_ADD, 0, 4, 1, 0, 0, 0, 0), -1, "R10");
        send(r_w(6, 1, 2, 8), 1, NONE, -1, "R10");
        send(i_w(4, 9, 0, 16'h0), 1, NONE, -1, "R10");
        clr(0, 4);
        send(i_w(4, 9, 0, 16'h0), 0, mk(OP_VLOAD, 0, 9, 1, 1, 0, 0, 5), -1, "R10");
        clr(1, 3);
        send(r_w(7, 3, 1, 0), 0, mk(OP_VSUB, 3, 0, 0, 0, 0, 0, 5), -1, "R11");
        vlen_src = 32'h3;
        send(r_w(9, 1, 2, 12), 0, mk(OP_VCMP, 1, 0, 0, 0, 0, 0, 3), -1, "R5");
        // R1 R2: undefined format and unknown opcodes
        send(32'hFFFFFFFF, 0, mk(OP_NOP, 0, 0, 0, 0, 0, 0, 0), -1, "R1");
        send(r_w(20, 5, 5, 6), 0, mk(OP_NOP, 0, 0, 0, 0, 0, 0, 0), -1, "R2");
        send(i_w(9, 5, 10, 16'h7), 0, mk(OP_NOP, 0, 0, 0, 0, 0, 0, 0), -1, "R2");
        // R11: claim beats a same-cycle clear of the same register
        send(r_w(0, 0, 0, 20), 0, mk(OP_ADD, 0, 20, 1, 0, 0, 0, 0), 20, "R11");
        send(r_w(0, 20, 0, 21), 1, NONE, -1, "R11");
        send(r_w(0, 0, 0, 22), 0, mk(OP_ADD, 0, 22, 1, 0, 0, 0, 0), 20, "R11");
        send(r_w(0, 20, 0, 23), 0, mk(OP_ADD, 20, 23, 1, 0, 0, 0, 0), -1, "R11");
        // R12: back-pressure blocks transfer and claim
        @(posedge clk); #1;
        out_ready = 0; in_valid = 1; in_insn = r_w(0, 0, 0, 24);
        @(negedge clk);
        chk(!in_ready && out_valid, "R12", "held by sink",
            64'({in_ready, out_valid}), 64'(2'b01));
        @(posedge clk); #1;
        in_valid = 0; out_ready = 1;
        send(r_w(0, 24, 0, 25), 0, mk(OP_ADD, 24, 25, 1, 0, 0, 0, 0), -1, "R12");
        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "R3", "outputs missing", 64'(exp_q.size()), 64'(0));
      end
      begin
        #2000000;
        chk(1'b0, "R3", "watchdog expired", 64'(0), 64'(1));
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule